// File: doc/BRIEF.md
# Bidirectional Shift-Latch Row Driver Core

This block is the logic core of a row driver with a parameterised number of channels, 40 by default. Serial data moves through a chain of stages, one position per rising clock edge, in a direction chosen by a select input. Two serial ends are shared: the head end sits next to stage 1 and the tail end sits next to the last stage. Whichever end receives data in the current direction is the input, and the other end drives out the stage next to it. An active-low clear empties the chain at once, whether or not a clock edge arrives.

A level-sensitive latch follows the chain. It has two modes. TRACK applies while `hold_en` is low, and the channel data follows the chain. HOLD applies while `hold_en` is high, and the channel data keeps the value it had at the moment `hold_en` rose. A TRACK→HOLD transition happens when `hold_en` rises. A HOLD→TRACK transition happens when it falls.

A combinational output stage comes last. It picks one of four modes from `force_en` and `flip`:

| Mode | force_en | flip | Channel outputs |
|---|---|---|---|
| PASS | 0 | 0 | the latched bits |
| INVERT | 0 | 1 | the latched bits, inverted |
| ALL_HIGH | 1 | 0 | every channel 1 |
| ALL_LOW | 1 | 1 | every channel 0 |

The mode changes as soon as either control changes. There is no clocked delay.

Top module: `row_driver_core`

## Requirements
- R1: While `clear_n` is low, every stage reads 0 at once, with or without a clock edge, and clocks are ignored. With `hold_en` low, `force_en` low and `flip` low, `chan_out` is then all zeros and both serial outputs are 0.
- R2: With `shift_up` = 1, each rising edge of `clk` loads `head_in` into stage 1 and moves stage k into stage k+1. `chan_out[0]` reflects stage 1 and `chan_out[N-1]` reflects the last stage.
- R3: With `shift_up` = 0, each rising edge loads `tail_in` into the last stage and moves stage k+1 into stage k.
- R4: Between rising edges of `clk` the stages hold their values, whatever happens on `head_in`, `tail_in` or `shift_up`.
- R5: `head_out` always shows stage 1 and `tail_out` always shows the last stage. After N edges in one direction, the first bit entered appears on the output end of that direction.
- R6: `tail_oe` equals `shift_up` and `head_oe` equals its inverse, so exactly one end is driven.
- R7: While `hold_en` is low (TRACK), the latched data equals the stage contents.
- R8: While `hold_en` is high (HOLD), the latched data keeps the stage contents from just before `hold_en` rose. Shifts and clears in that time do not change it.
- R9: The output modes PASS, INVERT, ALL_HIGH and ALL_LOW apply as listed in the table above. `chan_out` changes without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| clear_n | input | 1 | Asynchronous clear of the stages, active low |
| shift_up | input | 1 | 1: head end in, tail end out; 0: tail end in, head end out |
| head_in | input | 1 | Serial input at the stage-1 end |
| head_out | output | 1 | Stage 1 value |
| head_oe | output | 1 | Drive enable for the head end |
| tail_in | input | 1 | Serial input at the last-stage end |
| tail_out | output | 1 | Last stage value |
| tail_oe | output | 1 | Drive enable for the tail end |
| hold_en | input | 1 | Latch hold, active high |
| force_en | input | 1 | Forces all channels to one level |
| flip | input | 1 | Output polarity reversal |
| chan_out | output | N | Channel outputs, bit 0 is channel 1 |

## Verification
The bench fills the whole chain in each direction and checks every channel after each edge. A reversed shift or an off-by-one end would show up as a misplaced bit and as a wrong serial output on the fortieth edge. It gates the clock to show that data moving on the serial pins without an edge changes nothing. It raises `hold_en`, then shifts and clears behind it: a latch that leaks, or a clear that reaches the latch, would change the held channels. It also flips the direction while idle to catch swapped drive enables, and it walks all four output modes, which would expose a swapped force level or polarity.

// File: rtl/rdrv_pkg.sv
package rdrv_pkg;

    typedef enum logic {
        SD_DOWN = 1'b0,
        SD_UP   = 1'b1
    } shift_dir_e;

    typedef enum logic {
        LM_TRACK = 1'b0,
        LM_HOLD  = 1'b1
    } latch_mode_e;

    typedef enum logic [1:0] {
        OM_PASS     = 2'd0,
        OM_INVERT   = 2'd1,
        OM_ALL_HIGH = 2'd2,
        OM_ALL_LOW  = 2'd3
    } out_mode_e;

    function automatic out_mode_e decode_out_mode(input logic force_en, input logic flip);
        out_mode_e m;
        unique case ({force_en, flip})
            2'b00:   m = OM_PASS;
            2'b01:   m = OM_INVERT;
            2'b10:   m = OM_ALL_HIGH;
            default: m = OM_ALL_LOW;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rdrv_shift.sv
module rdrv_shift
    import rdrv_pkg::*;
#(
    parameter int N = 40
) (
    input  logic         clk,
    input  logic         clear_n,
    input  shift_dir_e   dir,
    input  logic         head_in,
    input  logic         tail_in,
    output logic [N-1:0] stages
);

    logic [N-1:0] next_up;
    logic [N-1:0] next_down;

    // Per-stage neighbour selection for both directions.
    for (genvar i = 0; i < N; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign next_up[i] = head_in;
        end else begin : g_up
            assign next_up[i] = stages[i-1];
        end
        if (i == N-1) begin : g_last
            assign next_down[i] = tail_in;
        end else begin : g_down
            assign next_down[i] = stages[i+1];
        end
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            stages <= '0;
        end else begin
            unique case (dir)
                SD_UP:   stages <= next_up;
                SD_DOWN: stages <= next_down;
            endcase
        end
    end

    // R2: an upward edge moves every bit one place toward the tail
    a_r2_up_step: assert property (@(posedge clk) disable iff (!clear_n)
        (dir == SD_UP) |=> (stages == {$past(stages[N-2:0]), $past(head_in)}));

    // R3: a downward edge moves every bit one place toward the head
    a_r3_down_step: assert property (@(posedge clk) disable iff (!clear_n)
        (dir == SD_DOWN) |=> (stages == {$past(tail_in), $past(stages[N-1:1])}));

    // R1: clear dominates any edge
    a_r1_clear_empty: assert property (@(posedge clk)
        !clear_n |-> (stages == '0));

endmodule

// File: rtl/rdrv_latch.sv
module rdrv_latch
    import rdrv_pkg::*;
#(
    parameter int N = 40
) (
    input  logic         hold_en,
    input  logic [N-1:0] din,
    output logic [N-1:0] held
);

    latch_mode_e mode;

    always_comb begin
        unique case (hold_en)
            1'b1:    mode = LM_HOLD;
            default: mode = LM_TRACK;
        endcase
    end

    // Level-sensitive storage: transparent in TRACK, frozen in HOLD.
    always_latch begin
        if (mode == LM_TRACK) begin
            held <= din;
        end
    end

endmodule

// File: rtl/rdrv_outstage.sv
module rdrv_outstage
    import rdrv_pkg::*;
#(
    parameter int N = 40
) (
    input  logic         force_en,
    input  logic         flip,
    input  logic [N-1:0] held,
    output logic [N-1:0] drive
);

    out_mode_e mode;

    always_comb begin
        mode = decode_out_mode(force_en, flip);
        unique case (mode)
            OM_PASS:     drive = held;
            OM_INVERT:   drive = ~held;
            OM_ALL_HIGH: drive = '1;
            OM_ALL_LOW:  drive = '0;
        endcase
    end

endmodule

// File: rtl/row_driver_core.sv
module row_driver_core
    import rdrv_pkg::*;
#(
    parameter int N = 40
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         shift_up,
    input  logic         head_in,
    output logic         head_out,
    output logic         head_oe,
    input  logic         tail_in,
    output logic         tail_out,
    output logic         tail_oe,
    input  logic         hold_en,
    input  logic         force_en,
    input  logic         flip,
    output logic [N-1:0] chan_out
);

    localparam int LAST = N - 1;

    shift_dir_e   dir;
    logic [N-1:0] sr_q;
    logic [N-1:0] lat_q;

    assign dir = shift_up ? SD_UP : SD_DOWN;

    rdrv_shift #(.N(N)) u_shift (
        .clk     (clk),
        .clear_n (clear_n),
        .dir     (dir),
        .head_in (head_in),
        .tail_in (tail_in),
        .stages  (sr_q)
    );

    rdrv_latch #(.N(N)) u_latch (
        .hold_en (hold_en),
        .din     (sr_q),
        .held    (lat_q)
    );

    rdrv_outstage #(.N(N)) u_out (
        .force_en (force_en),
        .flip     (flip),
        .held     (lat_q),
        .drive    (chan_out)
    );

    always_comb begin
        head_out = sr_q[0];
        tail_out = sr_q[LAST];
        unique case (dir)
            SD_UP:   begin head_oe = 1'b0; tail_oe = 1'b1; end
            SD_DOWN: begin head_oe = 1'b1; tail_oe = 1'b0; end
        endcase
    end

    // R6: exactly one serial end is driven
    a_r6_single_driver: assert property (@(posedge clk)
        $onehot0({head_oe, tail_oe}) && (head_oe || tail_oe));

    // R5: on an upward edge the tail output takes the stage before the last
    a_r5_tail_follows: assert property (@(posedge clk) disable iff (!clear_n)
        shift_up |=> (tail_out == $past(sr_q[LAST-1])));

    // R8: the latch does not move while hold stays high across an edge
    a_r8_latch_frozen: assert property (@(posedge clk) disable iff (!clear_n)
        (hold_en && $past(hold_en)) |-> $stable(lat_q));

    // R9: forcing with normal polarity drives every channel high
    a_r9_force_high: assert property (@(posedge clk) disable iff (!clear_n)
        (force_en && !flip) |-> ($countones(chan_out) == N));

endmodule

// File: tb/row_driver_core_tb.sv
module row_driver_core_tb;

    localparam int N = 40;

    typedef struct {
        logic [N-1:0] out;
        logic         h_out;
        logic         t_out;
        logic         h_oe;
        logic         t_oe;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic gate = 1'b0;
    logic sclk;
    logic clear_n = 1'b0, shift_up = 1'b1, head_in = 1'b0, tail_in = 1'b0;
    logic hold_en = 1'b0, force_en = 1'b0, flip = 1'b0;
    logic head_out, head_oe, tail_out, tail_oe;
    logic [N-1:0] chan_out;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    exp_t q[$];
    logic [N-1:0] m_sr = '0;
    logic [N-1:0] m_lat = '0;
    logic m_hold = 1'b0;

    always #4 clk = ~clk;
    assign sclk = clk & gate;   // gate changes only while clk is low

    row_driver_core #(.N(N)) u_dut (
        .clk(sclk), .clear_n(clear_n), .shift_up(shift_up),
        .head_in(head_in), .head_out(head_out), .head_oe(head_oe),
        .tail_in(tail_in), .tail_out(tail_out), .tail_oe(tail_oe),
        .hold_en(hold_en), .force_en(force_en), .flip(flip),
        .chan_out(chan_out)
    );

    function automatic logic pat(input int seed, input int k);
        return 1'(((k * 7 + seed * 3) % 5) < 2);
    endfunction

    // Driver: applies one cycle of stimulus and pushes the expected result.
    task automatic step(input logic hi, input logic ti, input logic up, input logic hd,
                        input logic fe, input logic fl, input logic pulse,
                        input logic cn, input string tag);
        exp_t e;
        logic [N-1:0] lat;
        @(negedge clk);
        if (hd && !m_hold) m_lat = m_sr;
        head_in = hi; tail_in = ti; shift_up = up; hold_en = hd;
        force_en = fe; flip = fl; clear_n = cn; gate = pulse;
        m_hold = hd;
        if (!cn) m_sr = '0;
        else if (pulse) m_sr = up ? {m_sr[N-2:0], hi} : {ti, m_sr[N-1:1]};
        lat = hd ? m_lat : m_sr;
        e.out   = fe ? {N{~fl}} : (lat ^ {N{fl}});
        e.h_out = m_sr[0];
        e.t_out = m_sr[N-1];
        e.h_oe  = ~up;
        e.t_oe  = up;
        e.tag   = tag;
        q.push_back(e);
    endtask

    // Monitor: compares one expected item per cycle, after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                tests++;
                if (chan_out !== e.out || head_out !== e.h_out || tail_out !== e.t_out ||
                    head_oe !== e.h_oe || tail_oe !== e.t_oe) begin
                    fails++;
                    $display("FAIL %s: out=%h h=%b t=%b oe=%b%b expected out=%h h=%b t=%b oe=%b%b",
                             e.tag, chan_out, head_out, tail_out, head_oe, tail_oe,
                             e.out, e.h_out, e.t_out, e.h_oe, e.t_oe);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state with edges arriving during clear
        step(1, 1, 1, 0, 0, 0, 1, 0, "R1");
        step(1, 0, 1, 0, 0, 0, 1, 0, "R1");
        // R2: fill upward; R5 on the final edge (tail shows the first bit)
        for (int k = 0; k < N; k++)
            step(pat(1, k), 0, 1, 0, 0, 0, 1, 1, (k == N-1) ? "R5" : "R2");
        // R4: serial pins move with no edge
        for (int k = 0; k < 4; k++)
            step(k[0], ~k[0], 1, 0, 0, 0, 0, 1, "R4");
        step(0, 1, 0, 0, 0, 0, 0, 1, "R4");
        // R8: hold, then shift downward behind it (serial ends still move, R3)
        step(0, 0, 0, 1, 0, 0, 0, 1, "R8");
        for (int k = 0; k < 6; k++)
            step(0, pat(2, k), 0, 1, 0, 0, 1, 1, "R8");
        // R7: release hold, channels catch up with the stages
        step(0, 0, 0, 0, 0, 0, 0, 1, "R7");
        // R3: fill downward; R5 on the final edge at the head end
        for (int k = 0; k < N; k++)
            step(0, pat(3, k), 0, 0, 0, 0, 1, 1, (k == N-1) ? "R5" : "R3");
        // R6: direction changes while idle swap the drive enables
        step(0, 0, 1, 0, 0, 0, 0, 1, "R6");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R6");
        step(0, 0, 1, 0, 0, 0, 0, 1, "R6");
        // R8: clear behind hold leaves channels untouched
        step(0, 0, 1, 1, 0, 0, 0, 1, "R8");
        step(1, 0, 1, 1, 0, 0, 1, 0, "R8");
        step(0, 0, 1, 1, 0, 0, 0, 1, "R8");
        // R1: releasing hold shows the cleared chain
        step(0, 0, 1, 0, 0, 0, 0, 1, "R1");
        // R2: refill upward with another pattern
        for (int k = 0; k < N; k++)
            step(pat(4, k), 0, 1, 0, 0, 0, 1, 1, "R2");
        // R9: all four output modes, with no edge
        step(0, 0, 1, 0, 0, 0, 0, 1, "R9");
        step(0, 0, 1, 0, 0, 1, 0, 1, "R9");
        step(0, 0, 1, 0, 1, 0, 0, 1, "R9");
        step(0, 0, 1, 0, 1, 1, 0, 1, "R9");
        // R9: modes on held data while the chain keeps shifting
        step(0, 0, 1, 1, 0, 1, 0, 1, "R9");
        step(1, 0, 1, 1, 0, 1, 1, 1, "R9");
        step(0, 0, 1, 1, 1, 0, 1, 1, "R9");
        step(0, 0, 1, 0, 0, 0, 0, 1, "R7");
        repeat (4) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule